// File: doc/BRIEF.md
# Buffered Multi-Compare PWM Channel

This block produces one pulse-width-modulated output from a 16-bit up-counter. The counter starts at a programmable start value, advances once per enabled tick and returns to the start value after it reaches the period value. One compare register drives the output high and another drives it low, so the high time and the period can be set independently. Six compare registers each raise a sticky status flag when the counter passes their value. A reload flag marks every period boundary. Any enabled flag raises the interrupt request.

Software reaches the block through a simple register port. Every write to the start value or to a compare register lands in a shadow copy. The shadow copies move into the working set together at the next period boundary, or at the moment the channel is started, but only when software has armed a load-ok bit. That bit then clears itself, which tells software that the commit has happened. A run input starts and stops the channel. An invert input complements the output. While stopped, the output sits at its idle level.

Register map (addr_i): 0 start value, 1 to 6 compare registers C0 to C5 (C1 is the period value, C2 sets the output high, C3 sets it low), 7 control (bit 0 load-ok), 8 status, 9 interrupt enable, 10 counter value (read only). Reads of 0 to 6 return the shadow copies.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While running, the counter (readable at address 10) starts from the start value, adds one on each cycle with tick_i high and holds on each cycle with tick_i low. On a tick where it equals C1, it returns to the start value instead. The period is C1 minus start plus one ticks.
- R2: On a tick where the counter equals C2, the pre-inversion output is high from the next cycle. On a tick where it equals C3, the output is low from the next cycle. When C2 equals C3, the low action wins and the output stays low.
- R3: Status bit k (k = 0 to 5) sets on a tick where the counter equals Ck. A compare value outside the range the counter visits never sets its flag.
- R4: Status bit 12 (reload) sets on each tick where the counter returns to the start value.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R6: Writes to addresses 0 to 6 change only the shadow copy, which reads back at once. The working values change only at a period boundary or a start while control bit 0 (load-ok) is 1. Load-ok then reads 0.
- R7: irq_o is high exactly when some status bit is 1 and the interrupt-enable bit at the same position (0 to 5, 12) is 1.
- R8: pwm_o is the pre-inversion output XOR invert_i.
- R9: From the cycle after run_i falls, the pre-inversion output is 0 and the counter holds its value.
- R10: On the cycle when run_i rises, the counter loads the start value. If load-ok is 1, it first commits the shadow copies, so counting begins at the new start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| run_i | input | 1 | Channel run control |
| tick_i | input | 1 | Count enable |
| invert_i | input | 1 | Output polarity inversion |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a running channel whose period register has been rewritten but not yet committed. The bench writes a longer period into the shadow copy in the middle of a run and samples the counter readback over several periods, to show the old limit still applies. It then arms load-ok, waits for the bit to clear and checks that the counter now reaches the new limit. The output waveforms are predicted per cycle from the start, period and edge values and queued for a monitor. This covers a nonzero start value, inversion and coincident set and clear edges.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int NREG    = 7;  // start value + C0..C5
  localparam int NCMP    = 6;
  localparam int IDX_ST  = 0;
  localparam int IDX_PER = 2;
  localparam int RLD_BIT = 12;

  typedef enum logic [3:0] {
    A_START = 4'd0,
    A_CTRL  = 4'd7,
    A_STS   = 4'd8,
    A_IEN   = 4'd9,
    A_CNT   = 4'd10
  } addr_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [3:0]               addr_i,
  input  logic [CW-1:0]            wdata_i,
  input  logic                     load_i,
  output logic [NREG-1:0][CW-1:0]  buf_o,
  output logic [NREG-1:0][CW-1:0]  act_o,
  output logic                     ldok_o
);
  logic [NREG-1:0][CW-1:0] buf_q, act_q;
  logic ldok_q;
  logic ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      ldok_q <= 1'b0;
    end else begin
      if (load_i && ldok_q) begin
        act_q  <= buf_q;
        ldok_q <= 1'b0;
      end
      if (ctrl_wr) ldok_q <= wdata_i[0];
      for (int i = 0; i < NREG; i++) begin
        if (wr_en_i && addr_i == 4'(i)) buf_q[i] <= wdata_i;
      end
    end
  end

  assign buf_o  = buf_q;
  assign act_o  = act_q;
  assign ldok_o = ldok_q;

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q)); // R6
  AST_LDOK_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ldok_q && !ctrl_wr) |=> !ldok_q); // R6
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          ldok_i,
  input  logic [CW-1:0] start_act_i,
  input  logic [CW-1:0] start_buf_i,
  input  logic [CW-1:0] per_act_i,
  output logic [CW-1:0] cnt_o,
  output logic          running_o,
  output logic          wrap_o,
  output logic          start_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q, next_start;

  assign start_o    = run_i && !run_q;
  assign running_o  = run_i && run_q;
  assign wrap_o     = running_o && tick_i && (cnt_q == per_act_i);
  assign next_start = ldok_i ? start_buf_i : start_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_i;
      if (start_o || wrap_o)       cnt_q <= next_start;
      else if (running_o && tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && !(running_o && tick_i)) |=> $stable(cnt_q)); // R1
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !ldok_i) |=> (cnt_q == $past(start_act_i))); // R10
endmodule

// File: rtl/pwm_edge_status.sv
module pwm_edge_status
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     running_i,
  input  logic                     tick_i,
  input  logic                     wrap_i,
  input  logic [CW-1:0]            cnt_i,
  input  logic [NCMP-1:0][CW-1:0]  cmp_i,
  input  logic                     wr_en_i,
  input  logic [3:0]               addr_i,
  input  logic [CW-1:0]            wdata_i,
  output logic                     out_o,
  output logic [CW-1:0]            sts_o,
  output logic [CW-1:0]            ien_o,
  output logic                     irq_o
);
  localparam logic [CW-1:0] FLAG_MASK = CW'((1 << RLD_BIT) | ((1 << NCMP) - 1));

  logic [NCMP-1:0] match;
  logic [CW-1:0]   set_v, clr_v, sts_q, ien_q;
  logic            ev, out_q;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign match[k] = (cnt_i == cmp_i[k]);
  end

  assign ev = running_i && tick_i;

  always_comb begin
    set_v = '0;
    set_v[NCMP-1:0] = ev ? match : '0;
    set_v[RLD_BIT]  = wrap_i;
    clr_v = (wr_en_i && addr_i == A_STS) ? (wdata_i & FLAG_MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      if (!run_i)               out_q <= 1'b0;
      else if (ev && match[3])  out_q <= 1'b0;  // low action wins
      else if (ev && match[2])  out_q <= 1'b1;
      sts_q <= (sts_q & ~clr_v) | set_v;
      if (wr_en_i && addr_i == A_IEN) ien_q <= wdata_i & FLAG_MASK;
    end
  end

  assign out_o = out_q;
  assign sts_o = sts_q;
  assign ien_o = ien_q;
  assign irq_o = |(sts_q & ien_q);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !out_q); // R9
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && match[3]) |=> !out_q); // R2
  AST_SET_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && match[2] && !match[3]) |=> out_q); // R2
  AST_W1C_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v == '0 && clr_v == '0) |=> $stable(sts_q)); // R5
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          invert_i,
  output logic          pwm_o,
  output logic          irq_o
);
  logic [NREG-1:0][CW-1:0] buf_v, act_v;
  logic [CW-1:0] cnt, sts, ien;
  logic ldok, running, wrap, start, out;

  pwm_shadow #(.CW(CW)) u_shadow (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .load_i (start || wrap),
    .buf_o  (buf_v),
    .act_o  (act_v),
    .ldok_o (ldok)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .run_i, .tick_i,
    .ldok_i      (ldok),
    .start_act_i (act_v[IDX_ST]),
    .start_buf_i (buf_v[IDX_ST]),
    .per_act_i   (act_v[IDX_PER]),
    .cnt_o       (cnt),
    .running_o   (running),
    .wrap_o      (wrap),
    .start_o     (start)
  );

  pwm_edge_status #(.CW(CW)) u_edge (
    .clk_i, .rst_ni, .run_i,
    .running_i (running),
    .tick_i,
    .wrap_i    (wrap),
    .cnt_i     (cnt),
    .cmp_i     (act_v[NREG-1:1]),
    .wr_en_i, .addr_i, .wdata_i,
    .out_o     (out),
    .sts_o     (sts),
    .ien_o     (ien),
    .irq_o
  );

  assign pwm_o = out ^ invert_i;

  always_comb begin
    rdata_o = '0;
    if (addr_i < 4'(NREG)) rdata_o = buf_v[addr_i[2:0]];
    else begin
      case (addr_i)
        A_CTRL:  rdata_o = {{(CW-1){1'b0}}, ldok};
        A_STS:   rdata_o = sts;
        A_IEN:   rdata_o = ien;
        A_CNT:   rdata_o = cnt;
        default: rdata_o = '0;
      endcase
    end
  end

  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts != '0)); // R7
endmodule

// File: tb/tb_pwm_cmp_chan.sv
module tb_pwm_cmp_chan;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, run = 0, tick = 1, inv = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic pwm, irq;
  int nchk = 0, nfail = 0;
  bit done = 0;
  bit expq[$];

  always #5 clk = ~clk;

  pwm_cmp_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .run_i(run), .tick_i(tick),
    .invert_i(inv), .pwm_o(pwm), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // monitor: compares output against queued predictions each cycle
  initial forever begin
    @(negedge clk);
    if (expq.size() > 0) begin
      bit e;
      e = expq.pop_front();
      chk(pwm === e, "R2/R8 waveform", int'(pwm), int'(e));
    end
  end

  task automatic wave(input int st, input int per, input int hi, input int lo,
                      input bit iv, input int n);
    int p;
    wr(0, 16'(st)); wr(2, 16'(per)); wr(3, 16'(hi)); wr(4, 16'(lo)); wr(7, 16'd1);
    inv = iv;
    @(negedge clk); addr = 4'd10; run = 1;
    @(posedge clk);
    p = per - st + 1;
    for (int j = 0; j < n; j++) begin
      bit e;
      int pos;
      pos = st + ((j + p - 1) % p);
      e = (j != 0) && (pos >= hi) && (pos < lo);
      expq.push_back(e ^ iv);
    end
    @(negedge clk);
    chk(rdata == 16'(st), "R10 start value loaded", int'(rdata), st);
    wait (expq.size() == 0);
    @(negedge clk); run = 0;
    @(negedge clk);
    chk(pwm == iv, "R9 idle level", int'(pwm), int'(iv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    int mx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pwm == 0, "R9 reset output", int'(pwm), 0);
    chk(irq == 0, "R7 reset irq", int'(irq), 0);
    rd(8, v); chk(v == 0, "R5 reset status", int'(v), 0);

    wr(3, 16'd5); rd(3, v);
    chk(v == 5, "R6 shadow readback", int'(v), 5);

    // R1 R2: basic waveform
    wave(0, 9, 2, 6, 0, 32);
    // clear all, then R1 R8 with nonzero start and inversion
    wr(8, 16'hFFFF);
    rd(8, v); chk(v == 0, "R5 clear all", int'(v), 0);
    wave(4, 11, 6, 10, 1, 30);
    // R3 R4: C0,C4,C5 = 0 lie outside 4..11
    rd(8, v); chk(v == 16'h100E, "R3 R4 flags in range only", int'(v), 16'h100E);
    wr(8, 16'h0000); rd(8, v);
    chk(v == 16'h100E, "R5 write zero no effect", int'(v), 16'h100E);
    wr(8, 16'h0002); rd(8, v);
    chk(v == 16'h100C, "R5 write one clears", int'(v), 16'h100C);
    // R7
    chk(irq == 0, "R7 no enable", int'(irq), 0);
    wr(9, 16'h0004); @(negedge clk);
    chk(irq == 1, "R7 enabled flag", int'(irq), 1);
    wr(8, 16'h0004); @(negedge clk);
    chk(irq == 0, "R7 flag cleared", int'(irq), 0);
    wr(9, 16'h1000); @(negedge clk);
    chk(irq == 1, "R4 reload irq", int'(irq), 1);
    wr(9, 16'h0000);

    // R2: coincident edges stay low
    wave(0, 9, 5, 5, 0, 24);

    // R6: period rewrite held until load-ok
    wr(0, 16'd0); wr(2, 16'd9); wr(7, 16'd1);
    @(negedge clk); run = 1;
    repeat (4) @(negedge clk);
    wr(2, 16'd19);
    rd(2, v); chk(v == 19, "R6 shadow shows new period", int'(v), 19);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      rd(10, v); if (int'(v) > mx) mx = int'(v);
    end
    chk(mx == 9, "R6 old period kept", mx, 9);
    wr(7, 16'd1);
    repeat (25) @(negedge clk);
    rd(7, v); chk(v == 0, "R6 load-ok self clear", int'(v), 0);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      rd(10, v); if (int'(v) > mx) mx = int'(v);
    end
    chk(mx == 19, "R6 new period committed", mx, 19);
    // R1: hold with tick low
    @(negedge clk); tick = 0;
    rd(10, v); repeat (5) @(negedge clk); rd(10, v2);
    chk(v == v2, "R1 hold without tick", int'(v2), int'(v));
    @(negedge clk); tick = 1;
    rd(10, v); rd(10, v2);
    chk(v2 != v, "R1 counts with tick", int'(v2), int'(v) + 1);
    // R9: hold after stop
    @(negedge clk); run = 0;
    rd(10, v); repeat (5) @(negedge clk); rd(10, v2);
    chk(v == v2, "R9 counter holds when stopped", int'(v2), int'(v));
    chk(pwm == 0, "R9 idle after stop", int'(pwm), 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule